// File: doc/BRIEF.md
# Serial Programming Loader for a Two-Channel Synthesizer

This block receives configuration words for a two-channel frequency synthesizer over three plain wires: a serial data line, a serial clock and a load strobe. Each rising edge of the serial clock moves one data bit into a 23-bit shift register, most significant bit first. While the load strobe is high, the register stops shifting. The whole word is then decoded and written into one of two channel registers. The destination is the transmit channel or the receive channel, and one control bit of the word picks it.

Each channel register holds three things: the main programmable-counter value, the swallow-counter value and a phase-polarity flag. Two settings are shared by both channels, the reference-ratio select and the monitor-output select, and every load refreshes them whatever the destination. The three serial pins are asynchronous to the system clock. They pass through a synchronizer whose depth is a parameter, and all storage is clocked by the system clock. The serial wires carry no back-pressure: this block cannot stall the sender. The sender must hold each serial level long enough for the synchronizer to see it, and each channel output changes only as a result of a load.

Word layout, with bit 22 entered first and bit 0 entered last: bit 22 reference-ratio select, bit 21 monitor select, bit 20 phase polarity, bits 19..9 main counter value, bits 8..2 swallow counter value, bit 1 a filler bit, bit 0 the destination bit.

Top module: `serial_prog_loader`

## Requirements
- R1: After reset, every output is zero.
- R2: Each rising serial-clock edge seen while the load strobe is low shifts the data bit into bit 0, and older bits move toward bit 22. After a load, the main counter value (bits 19..9), the swallow value (bits 8..2) and the polarity flag (bit 20) of the word appear unchanged on the selected channel's outputs.
- R3: A load whose bit 0 is 1 updates the transmit outputs and leaves the receive outputs unchanged.
- R4: A load whose bit 0 is 0 updates the receive outputs and leaves the transmit outputs unchanged.
- R5: Every load copies bit 22 to `ref_sel` and bit 21 to `mon_sel`, whichever channel is the destination.
- R6: Serial-clock edges that arrive while the load strobe is high do not change the shift register. A later load with no new shifting reproduces the same outputs.
- R7: The filler bit at position 1 has no effect on any output.
- R8: Shifting a full word without raising the load strobe changes no output.
- R9: When more than 23 bits are shifted before a load, only the last 23 decide the outputs.
- R10: The two channels hold their values independently. Loading one channel never disturbs what was last loaded into the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; bits are captured on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe; while high, the word is decoded and latched |
| tx_n | output | 11 | Transmit main counter value |
| tx_a | output | 7 | Transmit swallow counter value |
| tx_pol | output | 1 | Transmit phase polarity |
| rx_n | output | 11 | Receive main counter value |
| rx_a | output | 7 | Receive swallow counter value |
| rx_pol | output | 1 | Receive phase polarity |
| ref_sel | output | 1 | Shared reference-ratio select |
| mon_sel | output | 1 | Shared monitor-output select |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial level must last several system cycles, so that the synchronized strobe and the synchronized serial clock never change in the same cycle. They also assume the data bit is already settled when its serial-clock edge arrives. The bench holds every serial phase for four system cycles and every load pulse for ten. It changes data only while the serial clock is low, and it keeps the strobe low while it shifts, except in the one test that deliberately shifts during a load.

// File: rtl/serial_prog_pkg.sv
package serial_prog_pkg;
  localparam int WORD_W   = 23;
  localparam int N_W      = 11;
  localparam int A_W      = 7;
  localparam int CH_W     = 20;
  localparam int NUM_CH   = 2;
  localparam int CH_RX    = 0;
  localparam int CH_TX    = 1;
  localparam int DEST_POS = 0;
  localparam int FILL_POS = 1;
  localparam int A_LSB    = 2;
  localparam int N_LSB    = A_LSB + A_W;
  localparam int POL_POS  = N_LSB + N_W;
  localparam int MON_POS  = POL_POS + 1;
  localparam int REF_POS  = MON_POS + 1;

  typedef struct packed {
    logic           pol;
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic           rsv;
  } chan_word_t;

  typedef struct packed {
    logic ref_sel;
    logic mon_sel;
  } common_t;

  function automatic chan_word_t word_to_chan(input logic [WORD_W-1:0] w);
    chan_word_t c;
    c.pol = w[POL_POS];
    c.n   = w[N_LSB +: N_W];
    c.a   = w[A_LSB +: A_W];
    c.rsv = 1'b0;
    return c;
  endfunction

  function automatic common_t word_to_common(input logic [WORD_W-1:0] w);
    common_t s;
    s.ref_sel = w[REF_POS];
    s.mon_sel = w[MON_POS];
    return s;
  endfunction
endpackage

// File: rtl/serial_pin_sync.sv
module serial_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic data_i,
  input  logic load_i,
  output logic sclk_rise,
  output logic data_s,
  output logic load_s
);
  localparam int PINS = 3;

  logic [PINS-1:0] pin_in;
  logic [PINS-1:0] stage_q [STAGES];
  logic            sclk_prev;

  assign pin_in = {load_i, data_i, sclk_i};

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else if (g == 0) begin
          stage_q[g] <= pin_in;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= stage_q[STAGES-1][0];
  end

  assign sclk_rise = stage_q[STAGES-1][0] & ~sclk_prev;
  assign data_s    = stage_q[STAGES-1][1];
  assign load_s    = stage_q[STAGES-1][2];
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int WIDTH = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hold,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (step && !hold) begin
      word <= {word[WIDTH-2:0], din};
    end
  end
endmodule

// File: rtl/load_decoder.sv
module load_decoder
  import serial_prog_pkg::*;
(
  input  logic              load_s,
  input  logic [WORD_W-1:0] word,
  output logic [NUM_CH-1:0] chan_we,
  output chan_word_t        chan_d,
  output logic              common_we,
  output common_t           common_d
);
  always_comb begin
    chan_we = '0;
    if (load_s) begin
      if (word[DEST_POS]) chan_we[CH_TX] = 1'b1;
      else                chan_we[CH_RX] = 1'b1;
    end
  end

  assign chan_d    = word_to_chan(word);
  assign common_we = load_s;
  assign common_d  = word_to_common(word);
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/serial_prog_loader.sv
module serial_prog_loader
  import serial_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [N_W-1:0] tx_n,
  output logic [A_W-1:0] tx_a,
  output logic           tx_pol,
  output logic [N_W-1:0] rx_n,
  output logic [A_W-1:0] rx_a,
  output logic           rx_pol,
  output logic           ref_sel,
  output logic           mon_sel
);
  logic              sclk_rise;
  logic              data_s;
  logic              le_s;
  logic [WORD_W-1:0] shift_word;
  logic [NUM_CH-1:0] chan_we;
  chan_word_t        chan_d;
  chan_word_t        chan_q [NUM_CH];
  logic              common_we;
  common_t           common_d;
  common_t           common_q;

  serial_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(ser_clk), .data_i(ser_data),
    .load_i(ser_load), .sclk_rise(sclk_rise), .data_s(data_s), .load_s(le_s)
  );

  serial_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .step(sclk_rise), .hold(le_s),
    .din(data_s), .word(shift_word)
  );

  load_decoder u_dec (
    .load_s(le_s), .word(shift_word), .chan_we(chan_we), .chan_d(chan_d),
    .common_we(common_we), .common_d(common_d)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chan
      hold_reg #(.WIDTH(CH_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .we(chan_we[c]), .d(chan_d), .q(chan_q[c])
      );
    end
  endgenerate

  hold_reg #(.WIDTH($bits(common_t))) u_common (
    .clk(clk), .rst_n(rst_n), .we(common_we), .d(common_d), .q(common_q)
  );

  assign tx_n    = chan_q[CH_TX].n;
  assign tx_a    = chan_q[CH_TX].a;
  assign tx_pol  = chan_q[CH_TX].pol;
  assign rx_n    = chan_q[CH_RX].n;
  assign rx_a    = chan_q[CH_RX].a;
  assign rx_pol  = chan_q[CH_RX].pol;
  assign ref_sel = common_q.ref_sel;
  assign mon_sel = common_q.mon_sel;
endmodule

// File: rtl/serial_prog_loader_chk.sv
module serial_prog_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        le_q,
  input logic [22:0] word,
  input logic [18:0] tx_bits,
  input logic [18:0] rx_bits,
  input logic        ref_sel,
  input logic        mon_sel
);
  assert_tx_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (le_q && word[0]) |=> $stable(rx_bits));

  assert_rx_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (le_q && !word[0]) |=> $stable(tx_bits));

  assert_common_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |=> (ref_sel == $past(word[22]) && mon_sel == $past(word[21])));

  assert_shift_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    le_q |=> $stable(word));

  assert_no_load_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !le_q |=> ($stable(tx_bits) && $stable(rx_bits) && $stable(ref_sel) && $stable(mon_sel)));
endmodule

bind serial_prog_loader serial_prog_loader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .le_q(le_s), .word(shift_word),
  .tx_bits({tx_pol, tx_n, tx_a}), .rx_bits({rx_pol, rx_n, rx_a}),
  .ref_sel(ref_sel), .mon_sel(mon_sel)
);

// File: tb/test_serial_prog_loader.sv
module test_serial_prog_loader;
  logic clk = 0;
  logic rst_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [10:0] tx_n, rx_n;
  logic [6:0]  tx_a, rx_a;
  logic tx_pol, rx_pol, ref_sel, mon_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_prog_loader i_serial_prog_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .tx_n(tx_n), .tx_a(tx_a), .tx_pol(tx_pol),
    .rx_n(rx_n), .rx_a(rx_a), .rx_pol(rx_pol), .ref_sel(ref_sel), .mon_sel(mon_sel)
  );

  function automatic logic [22:0] mk(input bit refs, input bit mon, input bit pol,
      input logic [10:0] n, input logic [6:0] a, input bit fill, input bit dest);
    return {refs, mon, pol, n, a, fill, dest};
  endfunction

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic put_bit(input bit b);
    ser_data = b; cyc(4); ser_clk = 1; cyc(4); ser_clk = 0;
  endtask

  task automatic shift_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) put_bit(w[i]);
    cyc(4);
  endtask

  task automatic pulse_load();
    ser_load = 1; cyc(10); ser_load = 0; cyc(6);
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] outs();
    return {tx_pol, tx_n, tx_a, rx_pol, rx_n, rx_a, ref_sel, mon_sel};
  endfunction

  logic [18:0] exp_tx = '0, exp_rx = '0;
  logic        exp_ref = 0, exp_mon = 0;

  function automatic logic [39:0] expect_all();
    return {exp_tx, exp_rx, exp_ref, exp_mon};
  endfunction

  task automatic apply(input logic [22:0] w);
    if (w[0]) exp_tx = {w[20], w[19:9], w[8:2]};
    else      exp_rx = {w[20], w[19:9], w[8:2]};
    exp_ref = w[22]; exp_mon = w[21];
  endtask

  task automatic t_reset();
    check("R1 reset outputs", outs(), 40'd0);
  endtask

  task automatic t_tx_load();
    logic [22:0] w = mk(1, 0, 1, 11'd100, 7'd37, 0, 1);
    shift_word(w); pulse_load(); apply(w);
    check("R2 tx fields", {21'd0, tx_pol, tx_n, tx_a}, {21'd0, exp_tx});
    check("R3 rx untouched", {21'd0, rx_pol, rx_n, rx_a}, 40'd0);
    check("R5 common after tx", {38'd0, ref_sel, mon_sel}, {38'd0, 2'b10});
  endtask

  task automatic t_rx_load();
    logic [22:0] w = mk(0, 1, 0, 11'd2047, 7'd127, 0, 0);
    shift_word(w); pulse_load(); apply(w);
    check("R4 rx fields", {21'd0, rx_pol, rx_n, rx_a}, {21'd0, exp_rx});
    check("R10 tx held", {21'd0, tx_pol, tx_n, tx_a}, {21'd0, 1'b1, 11'd100, 7'd37});
    check("R5 common after rx", {38'd0, ref_sel, mon_sel}, {38'd0, 2'b01});
  endtask

  task automatic t_no_load();
    shift_word(mk(1, 1, 1, 11'd555, 7'd5, 0, 1));
    check("R8 no load no change", outs(), expect_all());
  endtask

  task automatic t_frozen();
    logic [22:0] w = mk(0, 0, 1, 11'd16, 7'd0, 0, 1);
    shift_word(w); apply(w);
    ser_load = 1; cyc(10);
    for (int i = 0; i < 23; i++) put_bit(1'b1);
    cyc(4);
    check("R6 frozen during load", outs(), expect_all());
    ser_load = 0; cyc(6);
    pulse_load();
    check("R6 reload same word", outs(), expect_all());
  endtask

  task automatic t_filler();
    logic [22:0] w = mk(1, 1, 0, 11'd1234, 7'd64, 1, 0);
    shift_word(w); pulse_load(); apply(w);
    check("R7 filler ignored", outs(), expect_all());
  endtask

  task automatic t_long();
    logic [22:0] w = mk(0, 1, 1, 11'd777, 7'd99, 0, 1);
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    shift_word(w); pulse_load(); apply(w);
    check("R9 last 23 bits", outs(), expect_all());
    check("R2 tx main value", {29'd0, tx_n}, {29'd0, 11'd777});
  endtask

  initial begin
    for (int i = 0; i < 60000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    t_reset();
    t_tx_load();
    t_rx_load();
    t_no_load();
    t_frozen();
    t_filler();
    t_long();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule